// File: doc/BRIEF.md
# Two-Phase Shared-RAM Register File

This block is the operand store of a small processor core. It holds 512 words of 32 bits in one dual-port RAM. Instruction words and register values live in the same memory. Each instruction takes two clocks, and a two-state sequencer shares the RAM's two ports between them.

In the **FETCH** state, port A reads the word at the program counter. At the same time, port B writes back the result of an earlier instruction. In the **OPER** state, the two ports read the source and destination operands. Their addresses come from two address fields of the word just fetched. The sequencer moves from FETCH to OPER by the **ISSUE** transition and from OPER back to FETCH by the **RETIRE** transition. It takes no other path.

The core around the block supplies the program counter and the writeback address, data and enable. It receives back three things:
- the fetched instruction, marked by `instr_valid`;
- the two operand words, marked by `opnd_valid`.

Decode, arithmetic and branching all sit outside the block.

Top module: `regmem_2phase`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the sequencer in FETCH and drives `instr_valid` and `opnd_valid` low in the following cycle. Memory contents are kept.
- R2: After reset is released, the sequencer alternates FETCH, OPER, FETCH, ... and each instruction takes exactly two clocks. `instr_valid` is high in every OPER cycle and low in every FETCH cycle.
- R3: The word at address `pc`, sampled in a FETCH cycle, appears on `instr` during the following OPER cycle.
- R4: The source operand address is bits [8:0] of the fetched word. The destination operand address is bits [17:9].
- R5: In the cycle after each OPER cycle:
  - `src_data` holds the word at the source address;
  - `dst_data` holds the word at the destination address;
  - `opnd_valid` is high for exactly that one cycle.
- R6: In a FETCH cycle with `wb_en` high, `wb_data` is stored at `wb_addr`. Later reads of that address return the stored word.
- R7: A writeback is visible to the operand reads of the OPER cycle that immediately follows it. A fetch from the address being written in the same cycle returns the new word.
- R8: With `wb_en` low in a FETCH cycle, memory is not changed, and the sequencer still advances to OPER.
- R9: The writeback inputs are ignored in OPER cycles, even with `wb_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc | input | 9 | Fetch address, sampled in FETCH |
| wb_en | input | 1 | Writeback enable, honoured in FETCH only |
| wb_addr | input | 9 | Writeback address |
| wb_data | input | 32 | Writeback word |
| instr | output | 32 | Fetched instruction word |
| instr_valid | output | 1 | High while `instr` holds a fresh fetch (OPER) |
| src_data | output | 32 | Source operand word |
| dst_data | output | 32 | Destination operand word |
| opnd_valid | output | 1 | One-cycle strobe for the operand words |

## Verification
Several stimulus patterns are used:
- A plain run of instructions with writeback disabled shows that the field extraction and the operand reads are correct. It includes one instruction whose source and destination are the same address, and addresses at both ends of the memory.
- A writeback into the operand that is read next tells forwarding-by-ordering apart from a stale read.
- A fetch from the address being written in the same cycle exercises the port collision.
- Writeback attempts with the enable low, and attempts made in the operand slot, are followed by reads of the targeted word. These show that the word was left untouched.
- A reset applied in the middle of an instruction checks that the sequencer restarts in the fetch slot with both strobes cleared.

// File: rtl/regmem_pkg.sv
package regmem_pkg;
    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_OPER  = 1'b1
    } slot_e;
endpackage

// File: rtl/regmem_dpram.sv
module regmem_dpram #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] a_addr,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_we,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (b_we) begin
            mem[b_addr] <= b_wdata;
        end
        a_rdata <= (b_we && (b_addr == a_addr)) ? b_wdata : mem[a_addr];
        b_rdata <= b_we ? b_wdata : mem[b_addr];
    end

    // R6
    wb_store_chk: assert property (@(posedge clk) disable iff (rst)
        b_we |=> (mem[$past(b_addr)] == $past(b_wdata)));
endmodule

// File: rtl/regmem_phase_fsm.sv
module regmem_phase_fsm
    import regmem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic fetch_slot,
    output logic oper_slot
);
    slot_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_FETCH: state_d = PH_OPER;   // ISSUE
            PH_OPER:  state_d = PH_FETCH;  // RETIRE
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        fetch_slot = 1'b0;
        oper_slot  = 1'b0;
        unique case (state_q)
            PH_FETCH: fetch_slot = 1'b1;
            PH_OPER:  oper_slot  = 1'b1;
        endcase
    end

    // R2
    issue_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_slot |=> oper_slot);
    // R2
    retire_chk: assert property (@(posedge clk) disable iff (rst)
        oper_slot |=> fetch_slot);
endmodule

// File: rtl/regmem_2phase.sv
module regmem_2phase #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pc,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    output logic [DATA_W-1:0] instr,
    output logic              instr_valid,
    output logic [DATA_W-1:0] src_data,
    output logic [DATA_W-1:0] dst_data,
    output logic              opnd_valid
);
    localparam int SRC_LSB = 0;
    localparam int DST_LSB = SRC_LSB + ADDR_W;

    logic              fetch_slot, oper_slot;
    logic [ADDR_W-1:0] ram_a_addr, ram_b_addr;
    logic              ram_we;
    logic [DATA_W-1:0] q_a, q_b;
    logic              opnd_v_q;

    regmem_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .fetch_slot (fetch_slot),
        .oper_slot  (oper_slot)
    );

    always_comb begin
        if (fetch_slot) begin
            ram_a_addr = pc;
            ram_b_addr = wb_addr;
        end else begin
            ram_a_addr = q_a[SRC_LSB +: ADDR_W];
            ram_b_addr = q_a[DST_LSB +: ADDR_W];
        end
        ram_we = fetch_slot & wb_en & ~rst;
    end

    regmem_dpram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .a_addr  (ram_a_addr),
        .a_rdata (q_a),
        .b_addr  (ram_b_addr),
        .b_we    (ram_we),
        .b_wdata (wb_data),
        .b_rdata (q_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_v_q <= 1'b0;
        end else begin
            opnd_v_q <= oper_slot;
        end
    end

    assign instr       = q_a;
    assign instr_valid = oper_slot;
    assign src_data    = q_a;
    assign dst_data    = q_b;
    assign opnd_valid  = opnd_v_q;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!opnd_valid && !instr_valid));
    // R5
    opnd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        opnd_valid |=> !opnd_valid);
    // R5
    opnd_after_oper_chk: assert property (@(posedge clk) disable iff (rst)
        opnd_valid |-> $past(instr_valid));
endmodule

// File: tb/regmem_2phase_tb.sv
module regmem_2phase_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  pc = '0;
    logic        wb_en = 1'b0;
    logic [8:0]  wb_addr = '0;
    logic [31:0] wb_data = '0;
    logic [31:0] instr, src_data, dst_data;
    logic        instr_valid, opnd_valid;

    always #4 clk = ~clk;

    regmem_2phase u_dut (
        .clk(clk), .rst(rst), .pc(pc), .wb_en(wb_en), .wb_addr(wb_addr),
        .wb_data(wb_data), .instr(instr), .instr_valid(instr_valid),
        .src_data(src_data), .dst_data(dst_data), .opnd_valid(opnd_valid)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mref [512];
    bit          kref [512];
    int          phase = 0;
    bit          exp_iv = 0, exp_ov = 0;
    logic [31:0] fetched = '0;
    bit          fk = 0;
    logic [31:0] exp_src = '0, exp_dst = '0;
    bit          sk = 0, dk = 0;
    string       cur_tag = "R1";
    string       vtag = "R1";

    function automatic logic [31:0] mk(int k, int s, int d);
        return {14'(k), 9'(d), 9'(s)};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        if (rst) begin
            phase = 0; exp_iv = 0; exp_ov = 0;
        end else if (phase == 0) begin
            if (wb_en) begin
                mref[wb_addr] = wb_data;
                kref[wb_addr] = 1;
            end
            fetched = mref[pc];
            fk = kref[pc];
            exp_iv = 1; exp_ov = 0; phase = 1;
        end else begin
            // R4: source field bits [8:0], destination field bits [17:9]
            sk = fk && kref[fetched[8:0]];
            dk = fk && kref[fetched[17:9]];
            exp_src = mref[fetched[8:0]];
            exp_dst = mref[fetched[17:9]];
            exp_iv = 0; exp_ov = 1; phase = 0;
        end
    endtask

    task automatic compare_all();
        chk(vtag, "instr_valid", 32'(instr_valid), 32'(exp_iv));
        chk(vtag, "opnd_valid", 32'(opnd_valid), 32'(exp_ov));
        if (exp_iv && fk) chk((cur_tag == "R7") ? "R7" : "R3", "instr", instr, fetched);
        if (exp_ov && sk) chk(cur_tag, "src_data", src_data, exp_src);
        if (exp_ov && dk) chk(cur_tag, "dst_data", dst_data, exp_dst);
    endtask

    task automatic step(bit r, logic [8:0] p, bit we, logic [8:0] wa, logic [31:0] wd);
        rst = r; pc = p; wb_en = we; wb_addr = wa; wb_data = wd;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic instr_cycle(logic [8:0] p, bit we, logic [8:0] wa, logic [31:0] wd);
        step(1'b0, p, we, wa, wd);
        step(1'b0, 9'd0, 1'b0, 9'd0, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            kref[i] = 0;
            mref[i] = '0;
        end
        @(negedge clk);
        cur_tag = "R1"; vtag = "R1";
        for (int i = 0; i < 3; i++) step(1'b1, 9'd0, 1'b0, 9'd0, 32'd0);
        vtag = "R2";

        // R6: load registers and program through the writeback path
        cur_tag = "R6";
        for (int i = 0; i < 8; i++)
            instr_cycle(9'd0, 1'b1, 9'(100 + i), 32'hA5000000 + 32'(i * 32'h1111));
        instr_cycle(9'd0, 1'b1, 9'd511, 32'hFEEDF00D);
        instr_cycle(9'd0, 1'b1, 9'd120, 32'h12012012);
        instr_cycle(9'd0, 1'b1, 9'd121, 32'h12112112);
        instr_cycle(9'd0, 1'b1, 9'd0, mk(1, 100, 101));
        instr_cycle(9'd0, 1'b1, 9'd1, mk(2, 107, 100));
        instr_cycle(9'd0, 1'b1, 9'd2, mk(3, 103, 103));
        instr_cycle(9'd0, 1'b1, 9'd3, mk(4, 511, 0));
        instr_cycle(9'd0, 1'b1, 9'd4, mk(5, 0, 511));
        instr_cycle(9'd0, 1'b1, 9'd8, mk(6, 120, 121));

        instr_cycle(9'd0, 1'b0, 9'd0, 32'd0);
        // R5 / R4: run the program with writeback off
        cur_tag = "R5";
        for (int i = 0; i < 3; i++) instr_cycle(9'(i), 1'b0, 9'd0, 32'd0);
        cur_tag = "R4";
        instr_cycle(9'd3, 1'b0, 9'd0, 32'd0);
        instr_cycle(9'd4, 1'b0, 9'd0, 32'd0);

        // R7: writeback into the operand read next, and fetch collision
        cur_tag = "R7";
        instr_cycle(9'd8, 1'b1, 9'd120, 32'h0BADCAFE);
        instr_cycle(9'd9, 1'b1, 9'd9, mk(7, 121, 120));

        // R8: enable low leaves the word unchanged
        cur_tag = "R8";
        instr_cycle(9'd0, 1'b0, 9'd100, 32'hDEADDEAD);
        instr_cycle(9'd0, 1'b0, 9'd0, 32'd0);

        // R9: writeback attempt during the operand slot is ignored
        cur_tag = "R9";
        step(1'b0, 9'd1, 1'b0, 9'd0, 32'd0);
        step(1'b0, 9'd0, 1'b1, 9'd101, 32'hBEEFBEEF);
        instr_cycle(9'd0, 1'b0, 9'd0, 32'd0);
        instr_cycle(9'd2, 1'b0, 9'd0, 32'd0);

        // R1: reset in the middle of an instruction
        cur_tag = "R1";
        step(1'b0, 9'd1, 1'b0, 9'd0, 32'd0);
        vtag = "R1";
        step(1'b1, 9'd0, 1'b1, 9'd107, 32'h77777777);
        vtag = "R2";
        cur_tag = "R5";
        instr_cycle(9'd1, 1'b0, 9'd0, 32'd0);
        instr_cycle(9'd0, 1'b0, 9'd0, 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule